// File: doc/BRIEF.md
# PLL Feedback-Divider Ramp Sequencer

This block moves the feedback multiplier of a running PLL from its present value to a new one without dropping lock. It does not write the multiplier in one jump. It puts the PLL into its slowdown mode, loads the new value, and then lets the PLL's own dynamic-ramp hardware walk the multiplier across. The block drives register-style outputs: the multiplier field, two ramp step-size fields, a slowdown-mode bit and a dynamic-ramp enable bit. It also watches the ramp-done status that the PLL returns.

A requester pulses `req` with a target multiplier. The sequencer waits for a one-microsecond settling period between its setup writes, using a free-running microsecond tick. It then samples the ramp-done status once per tick, and gives up after a fixed number of samples. Whether or not the ramp completes, the sequencer always leaves slowdown mode and turns off the dynamic ramp. It then returns a single-cycle `done` or `timeout` pulse. A request for the multiplier that is already programmed completes at once and leaves every output unchanged.

Top module: `ndiv_ramp_seq`

## Requirements
- R1: During and right after reset, `coeff_n` equals N_RESET (default 40). `step_a`, `step_b`, `slowdown_en`, `ramp_en`, `done` and `timeout` are all zero.
- R2: A request accepted while idle whose `req_n` equals `coeff_n` raises `done` for one cycle on the following cycle. No other output changes.
- R3: When a request with a different multiplier is accepted, `step_a` becomes 0x2B and `step_b` becomes 0x0B on that clock edge. This happens one cycle before `slowdown_en` rises.
- R4: `slowdown_en` rises one cycle after acceptance. `coeff_n` takes the target value on the first `us_tick` seen after that. `ramp_en` rises on the first `us_tick` seen after the multiplier write. `coeff_n` changes only while `slowdown_en` is high and `ramp_en` is low.
- R5: `ramp_done_async` passes through a two-flop synchronizer. The synchronized value is sampled on every `us_tick` while `ramp_en` is high.
- R6: When a sample finds ramp-done high, `slowdown_en` and `ramp_en` both drop one cycle later. `done` pulses on the cycle after that.
- R7: After 500 samples with ramp-done low, the same cleanup happens, followed by a one-cycle `timeout` pulse. `coeff_n` keeps the target value.
- R8: A request that arrives while a sequence is running, or in the cycle where `done` or `timeout` is high, is ignored.
- R9: `done` and `timeout` are never high together, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| req | input | 1 | Start request |
| req_n | input | NW | Requested feedback multiplier |
| ramp_done_async | input | 1 | Ramp-complete status from the PLL, asynchronous |
| coeff_n | output | NW | Programmed feedback multiplier field |
| step_a | output | SW | Ramp step-size field A |
| step_b | output | SW | Ramp step-size field B |
| slowdown_en | output | 1 | Slowdown-mode control bit |
| ramp_en | output | 1 | Dynamic-ramp enable bit |
| done | output | 1 | Sequence finished normally (one cycle) |
| timeout | output | 1 | Ramp never completed (one cycle) |

## Verification
The hardest case to reach is the end of the poll window. This is where ramp-done is seen on the last allowed sample, or where it arrives just too late after the timeout decision. Reaching it needs the microsecond tick, the two synchronizer flops and the ramp stub's delay to line up exactly. The stimulus therefore uses a PLL stub with a programmable completion delay counted in ticks. It runs one full timeout with no completion and several delays close to the limit. A cycle-by-cycle reference model, fed the same tick and status stream, decides which outcome is correct on every clock.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_WAIT_N  = 3'd2,
    ST_WAIT_EN = 3'd3,
    ST_POLL    = 3'd4,
    ST_EXIT    = 3'd5,
    ST_DONE    = 3'd6,
    ST_TMO     = 3'd7
  } nrs_state_e;
endpackage

// File: rtl/nrs_sync.sv
module nrs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/nrs_tick_count.sv
module nrs_tick_count #(
  parameter int LIMIT = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  output logic last
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign last   = active && tick && (cnt_q == TOP);
  assign cnt_en = !active || tick;

  always_comb begin
    cnt_d = cnt_q;
    if (!active)   cnt_d = '0;
    else if (last) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP); // R7
endmodule

// File: rtl/nrs_fsm.sv
module nrs_fsm
  import nrs_pkg::*;
#(
  parameter int             NW      = 8,
  parameter int             SW      = 8,
  parameter logic [NW-1:0]  N_RESET = NW'(40),
  parameter logic [SW-1:0]  STEP_A  = SW'(8'h2B),
  parameter logic [SW-1:0]  STEP_B  = SW'(8'h0B)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [NW-1:0] req_n,
  input  logic          us_tick,
  input  logic          ramp_done_s,
  input  logic          settle_last,
  input  logic          poll_last,
  output logic          settle_active,
  output logic          poll_active,
  output logic [NW-1:0] coeff_n,
  output logic [SW-1:0] step_a,
  output logic [SW-1:0] step_b,
  output logic          slowdown_en,
  output logic          ramp_en,
  output logic          done,
  output logic          timeout
);
  nrs_state_e    state_q, state_d;
  logic [NW-1:0] tgt_q, coeff_q;
  logic [SW-1:0] stepa_q, stepb_q;
  logic          slow_q, ramp_q, ok_q;

  logic accept, coeff_ld, ramp_set, slow_set, bits_clr, ok_ld;

  assign accept   = (state_q == ST_IDLE) && req && (req_n != coeff_q);
  assign slow_set = (state_q == ST_SETUP);
  assign coeff_ld = (state_q == ST_WAIT_N) && settle_last;
  assign ramp_set = (state_q == ST_WAIT_EN) && settle_last;
  assign ok_ld    = (state_q == ST_POLL) && us_tick;
  assign bits_clr = (state_q == ST_EXIT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req) state_d = (req_n == coeff_q) ? ST_DONE : ST_SETUP;
      ST_SETUP:   state_d = ST_WAIT_N;
      ST_WAIT_N:  if (settle_last) state_d = ST_WAIT_EN;
      ST_WAIT_EN: if (settle_last) state_d = ST_POLL;
      ST_POLL:    if (us_tick && (ramp_done_s || poll_last)) state_d = ST_EXIT;
      ST_EXIT:    state_d = ok_q ? ST_DONE : ST_TMO;
      ST_DONE:    state_d = ST_IDLE;
      ST_TMO:     state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      stepa_q <= '0;
      stepb_q <= '0;
    end else if (accept) begin
      tgt_q   <= req_n;
      stepa_q <= STEP_A;
      stepb_q <= STEP_B;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        coeff_q <= N_RESET;
    else if (coeff_ld) coeff_q <= tgt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    slow_q <= 1'b0;
    else if (slow_set || bits_clr) slow_q <= slow_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ramp_q <= 1'b0;
    else if (ramp_set || bits_clr) ramp_q <= ramp_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ok_q <= 1'b0;
    else if (ok_ld) ok_q <= ramp_done_s;
  end

  assign settle_active = (state_q == ST_WAIT_N) || (state_q == ST_WAIT_EN);
  assign poll_active   = (state_q == ST_POLL);
  assign coeff_n       = coeff_q;
  assign step_a        = stepa_q;
  assign step_b        = stepb_q;
  assign slowdown_en   = slow_q;
  assign ramp_en       = ramp_q;
  assign done          = (state_q == ST_DONE);
  assign timeout       = (state_q == ST_TMO);

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout); // R9
  AST_STEPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slowdown_en) |-> (step_a == STEP_A && step_b == STEP_B)); // R3
  AST_RAMP_IN_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en |-> slowdown_en); // R4
  AST_N_WRITE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(coeff_n) |-> (slowdown_en && !ramp_en)); // R4
  AST_CLEAR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slowdown_en) |-> !ramp_en); // R6
  AST_TMO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (!slowdown_en && !ramp_en)); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |=> !slowdown_en); // R8
endmodule

// File: rtl/ndiv_ramp_seq.sv
module ndiv_ramp_seq #(
  parameter int            NW        = 8,
  parameter int            SW        = 8,
  parameter logic [NW-1:0] N_RESET   = NW'(40),
  parameter int            SETTLE_US = 1,
  parameter int            POLL_MAX  = 500,
  parameter int            SYNC_FF   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          us_tick,
  input  logic          req,
  input  logic [NW-1:0] req_n,
  input  logic          ramp_done_async,
  output logic [NW-1:0] coeff_n,
  output logic [SW-1:0] step_a,
  output logic [SW-1:0] step_b,
  output logic          slowdown_en,
  output logic          ramp_en,
  output logic          done,
  output logic          timeout
);
  logic ramp_done_s, settle_active, poll_active, settle_last, poll_last;

  nrs_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ramp_done_async), .q(ramp_done_s)
  );

  nrs_tick_count #(.LIMIT(SETTLE_US)) u_settle (
    .clk(clk), .rst_n(rst_n), .active(settle_active), .tick(us_tick),
    .last(settle_last)
  );

  nrs_tick_count #(.LIMIT(POLL_MAX)) u_poll (
    .clk(clk), .rst_n(rst_n), .active(poll_active), .tick(us_tick),
    .last(poll_last)
  );

  nrs_fsm #(.NW(NW), .SW(SW), .N_RESET(N_RESET)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .req_n(req_n), .us_tick(us_tick),
    .ramp_done_s(ramp_done_s), .settle_last(settle_last), .poll_last(poll_last),
    .settle_active(settle_active), .poll_active(poll_active),
    .coeff_n(coeff_n), .step_a(step_a), .step_b(step_b),
    .slowdown_en(slowdown_en), .ramp_en(ramp_en), .done(done), .timeout(timeout)
  );
endmodule

// File: tb/ndiv_ramp_seq_test.sv
module ndiv_ramp_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b0;
  logic       req = 1'b0;
  logic [7:0] req_n = 8'd0;
  logic       ramp_done_async = 1'b0;
  logic [7:0] coeff_n, step_a, step_b;
  logic       slowdown_en, ramp_en, done, timeout;

  int errors = 0;
  int checks = 0;
  int done_seen = 0;
  int tmo_seen = 0;
  int stub_delay = -1;
  int stub_cnt = 0;
  int tick_div = 0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  ndiv_ramp_seq uut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .req(req), .req_n(req_n),
    .ramp_done_async(ramp_done_async), .coeff_n(coeff_n), .step_a(step_a),
    .step_b(step_b), .slowdown_en(slowdown_en), .ramp_en(ramp_en),
    .done(done), .timeout(timeout)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Tick source and PLL ramp stub (stub counts ticks while ramp is enabled)
  always @(negedge clk) begin
    if (!ramp_en) begin
      stub_cnt = 0;
      ramp_done_async = 1'b0;
    end else begin
      if (us_tick) stub_cnt++;
      if (stub_delay >= 0 && stub_cnt >= stub_delay) ramp_done_async = 1'b1;
    end
    tick_div = (tick_div == 3) ? 0 : tick_div + 1;
    us_tick = (tick_div == 0);
  end

  // Behavioural reference model
  int         m_st;
  int         m_cnt;
  bit         m_ok, m_s1, m_s2;
  logic [7:0] m_n, m_tgt, m_a, m_b;
  bit         m_slow, m_ramp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_ok = 0; m_s1 = 0; m_s2 = 0;
      m_n = 8'd40; m_tgt = 0; m_a = 0; m_b = 0; m_slow = 0; m_ramp = 0;
    end else begin
      case (m_st)
        0: if (req) begin
             if (req_n == m_n) m_st = 6;
             else begin m_tgt = req_n; m_a = 8'h2B; m_b = 8'h0B; m_st = 1; end
           end
        1: begin m_slow = 1; m_st = 2; end
        2: if (us_tick) begin m_n = m_tgt; m_st = 3; end
        3: if (us_tick) begin m_ramp = 1; m_st = 4; m_cnt = 0; end
        4: if (us_tick) begin
             if (m_s2) begin m_ok = 1; m_st = 5; end
             else if (m_cnt == 499) begin m_ok = 0; m_st = 5; end
             else m_cnt++;
           end
        5: begin m_slow = 0; m_ramp = 0; m_st = m_ok ? 6 : 7; end
        default: m_st = 0;
      endcase
      m_s2 = m_s1;
      m_s1 = ramp_done_async;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check("R4 coeff_n", coeff_n, m_n);
      check("R3 step_a", step_a, m_a);
      check("R3 step_b", step_b, m_b);
      check("R4 slowdown_en", slowdown_en, m_slow);
      check("R5 ramp_en", ramp_en, m_ramp);
      check("R6 done", done, m_st == 6);
      check("R7 timeout", timeout, m_st == 7);
      check("R9 exclusive", done && timeout, 0);
      if (done) done_seen++;
      if (timeout) tmo_seen++;
    end
  end

  task automatic issue(input logic [7:0] v);
    @(negedge clk);
    req = 1'b1; req_n = v;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_end(input int base);
    for (int i = 0; i < 5000; i++) begin
      if (done_seen + tmo_seen > base) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 coeff_n reset", coeff_n, 40);
    check("R1 steps reset", {step_a, step_b}, 0);
    check("R1 bits reset", {slowdown_en, ramp_en, done, timeout}, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (4) @(negedge clk);

    // R2: same multiplier completes at once
    issue(8'd40);
    repeat (4) @(negedge clk);
    check("R2 done count", done_seen, 1);
    check("R2 steps untouched", step_a, 0);

    // R6: normal ramp
    stub_delay = 6;
    issue(8'd80);
    wait_end(1);
    check("R6 done count", done_seen, 2);
    check("R6 coeff_n", coeff_n, 80);
    check("R6 bits cleared", {slowdown_en, ramp_en}, 0);
    check("R3 step_a value", step_a, 8'h2B);

    // R8: request while busy is ignored
    stub_delay = 3;
    issue(8'd120);
    repeat (8) @(negedge clk);
    issue(8'd7);
    wait_end(2);
    repeat (10) @(negedge clk);
    check("R8 busy request dropped", coeff_n, 120);
    check("R8 single completion", done_seen, 3);

    // R8: request in the done cycle is ignored
    @(negedge clk);
    req = 1'b1; req_n = 8'd120;
    @(negedge clk);
    req_n = 8'd9;
    while (!done) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    repeat (12) @(negedge clk);
    check("R8 done-cycle request dropped", coeff_n, 120);
    check("R8 slowdown idle", slowdown_en, 0);

    // R7: never completes
    stub_delay = -1;
    issue(8'd200);
    wait_end(done_seen + tmo_seen);
    check("R7 timeout count", tmo_seen, 1);
    check("R7 coeff kept", coeff_n, 200);
    check("R7 bits cleared", {slowdown_en, ramp_en}, 0);

    // R5: completion near the poll limit, model decides outcome
    for (int d = 497; d <= 500; d++) begin
      automatic int base = done_seen + tmo_seen;
      stub_delay = d;
      issue((d[0]) ? 8'd60 : 8'd90);
      wait_end(base);
      check("R5 one outcome", done_seen + tmo_seen, base + 1);
    end

    // R5: fast completion
    stub_delay = 0;
    issue(8'd33);
    wait_end(done_seen + tmo_seen);
    check("R5 fast coeff", coeff_n, 33);

    cmp_on = 1'b0;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule